// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the clock dividers of a system clock generator and its output drivers. Each output group has a source clock: processor pair, peripheral bus, graphics port, reference and 48 MHz. The block passes that clock through, or parks it low. Three asynchronous active-low stop requests (processor, peripheral bus, graphics port) and one asynchronous active-low power-down request decide whether a group runs. A per-output enable bit from configuration holds a single output low.

All logic runs on one fast reference clock `clk`. The dividers are modelled as level signals that are synchronous to `clk`. Each stop request passes through a two-stage synchronizer. That synchronizer advances on rising edges of its own group's source. A group's run/park decision and its enable bits change only at the high-to-low transition of its source. As a result, every pulse that reaches an output is a whole pulse. Power-down overrides every stop input and every minimum-run rule. A registered acknowledge reports when every output sits low.

One peripheral-bus output runs free and ignores the peripheral stop request. After a restart, the gated peripheral outputs give at least a minimum number of pulses before they can be stopped again.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, every clock output and `pd_ack` are 0.
- R2: Every high pulse on a gated true output lasts exactly as long as the high phase of its source. Every high pulse on `cpu_c` lasts exactly as long as the low phase of the processor source. No shortened pulse appears on stop or restart.
- R3: After `cpu_stop_n` falls, `cpu_t` and `cpu_c` give no new rising edge later than 4 processor source periods, and both stay low. After `cpu_stop_n` rises, `cpu_t` rises within 4 processor periods. `cpu_t` and `cpu_c` are never high together.
- R4: A processor stop leaves the peripheral, graphics, reference and 48 MHz outputs running at their full pulse counts.
- R5: After `pci_stop_n` falls, the gated peripheral outputs give no new rising edge later than 4 peripheral periods. `pci_free` keeps running with no missing pulse.
- R6: After the gated peripheral outputs restart, they deliver at least `PCI_MIN_RUN` (default 10) pulses before a stop request can park them, unless power-down is active.
- R7: After `agp_stop_n` falls, the graphics outputs give no new rising edge later than 3 graphics periods.
- R8: When an enable bit (1 = run, 0 = held low) is 0, its output stays low. Its neighbours in the same group keep running.
- R9: While `pd_n` is low, every output parks low, including `pci_free`, reference and 48 MHz, whatever the stop inputs are. `pd_ack` goes high once all outputs are parked and quiet. While `pd_ack` is high, every output is 0. After `pd_n` rises, `pd_ack` falls and the clocks resume.
- R10: With no request active and all enables set, each output gives exactly one rising edge per source period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_src | input | 1 | Processor source clock level |
| pci_src | input | 1 | Peripheral-bus source clock level |
| agp_src | input | 1 | Graphics-port source clock level |
| ref_src | input | 1 | Reference source clock level |
| usb_src | input | 1 | 48 MHz source clock level |
| cpu_stop_n | input | 1 | Asynchronous processor stop request, active low |
| pci_stop_n | input | 1 | Asynchronous peripheral stop request, active low |
| agp_stop_n | input | 1 | Asynchronous graphics stop request, active low |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| cpu_en | input | 1 | Enable for the processor pair |
| pci_en | input | N_PCI | Enables for the gated peripheral outputs |
| pci_free_en | input | 1 | Enable for the free-running peripheral output |
| agp_en | input | N_AGP | Enables for the graphics outputs |
| ref_en | input | N_REF | Enables for the reference outputs |
| usb_en | input | 1 | Enable for the 48 MHz output |
| cpu_t | output | 1 | Processor clock, true side |
| cpu_c | output | 1 | Processor clock, complement side (parks low) |
| pci_clk | output | N_PCI | Gated peripheral clocks |
| pci_free | output | 1 | Free-running peripheral clock |
| agp_clk | output | N_AGP | Graphics clocks |
| ref_clk | output | N_REF | Reference clocks |
| usb_clk | output | 1 | 48 MHz clock |
| pd_ack | output | 1 | All outputs parked under power-down |

## Verification
The hardest case to reach is the minimum-run window. The peripheral group has to be parked first, then released, and then a stop request has to arrive while the restarted group is still inside its first pulses. The stimulus does this by waiting for the first restarted edge on the output and lowering `pci_stop_n` right away. It then counts the pulses that still get through. A second hard case is a shortened pulse, which only shows up if a gating decision lands mid-phase. A monitor measures the width of every pulse on each tracked output for the whole run, so each stop, restart, disable and power-down is judged on pulse width as well as edge count.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Stages of every request synchronizer.
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        GATE_PARKED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_e;

    // Requests seen by one gate at a decision point, already synchronized.
    typedef struct packed {
        logic pd;
        logic stop;
    } gate_req_t;

    // The next run/park state. It is applied only at a high-to-low source boundary.
    function automatic gate_state_e gate_next(
        input gate_state_e cur,
        input gate_req_t   req,
        input logic        min_ok
    );
        if (cur == GATE_RUNNING) begin
            return (req.pd || (req.stop && min_ok)) ? GATE_PARKED : GATE_RUNNING;
        end
        return (!req.pd && !req.stop) ? GATE_RUNNING : GATE_PARKED;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else if (adv_i) begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int N_OUT    = 1,
    parameter int MIN_RUN  = 0,
    parameter bit HAS_STOP = 1'b1,
    parameter bit HAS_COMP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_i,
    input  logic             stop_n_i,
    input  logic             pd_i,
    input  logic [N_OUT-1:0] en_i,
    output logic [N_OUT-1:0] out_o,
    output logic [N_OUT-1:0] comp_o,
    output logic             parked_o
);

    localparam int             CW   = $clog2(MIN_RUN + 2);
    localparam logic [CW-1:0]  LAST = CW'((MIN_RUN > 0) ? MIN_RUN - 1 : 0);

    logic             s1_q;
    logic             rise_w;
    logic             fall_w;
    logic             stop_w;
    logic             run_w;
    logic             min_ok_w;
    gate_state_e      state_q;
    logic [CW-1:0]    cnt_q;
    logic [N_OUT-1:0] en_q;
    gate_req_t        req_w;

    assign rise_w   = src_i & ~s1_q;
    assign fall_w   = ~src_i & s1_q;
    assign run_w    = (state_q == GATE_RUNNING);
    assign min_ok_w = (cnt_q >= LAST);
    assign req_w    = '{pd: pd_i, stop: stop_w};
    assign parked_o = ~run_w;

    // Stop synchronizer, clocked by rising edges of this group's own source.
    generate
        if (HAS_STOP) begin : g_stop
            clkstop_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_stop_sync (
                .clk   (clk),
                .rst   (rst),
                .adv_i (rise_w),
                .d_i   (~stop_n_i),
                .q_o   (stop_w)
            );
        end else begin : g_free
            assign stop_w = 1'b0 & ~stop_n_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b0;
            state_q <= GATE_PARKED;
            cnt_q   <= '0;
            en_q    <= '0;
            out_o   <= '0;
            comp_o  <= '0;
        end else begin
            s1_q <= src_i;
            if (fall_w) begin
                state_q <= gate_next(state_q, req_w, min_ok_w);
                en_q    <= en_i;
                if (!run_w) begin
                    cnt_q <= '0;
                end else if (!min_ok_w) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            out_o  <= {N_OUT{s1_q & run_w}} & en_q;
            comp_o <= HAS_COMP ? ({N_OUT{~s1_q & run_w}} & en_q) : '0;
        end
    end

    AST_GATE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        (state_q != $past(state_q)) |-> ($past(s1_q) && !$past(src_i))); // R2

    AST_MIN_RUN_HELD: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_w) && !$past(pd_i)) |-> ($past(cnt_q) == LAST)); // R6

    AST_PD_PARKS: assert property (@(posedge clk) disable iff (rst)
        (pd_i && fall_w) |=> !run_w); // R9

    AST_EN_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        (en_q != '1) |=> ((out_o & ~$past(en_q)) == '0)); // R8

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_PCI       = 10,
    parameter int N_AGP       = 3,
    parameter int N_REF       = 3,
    parameter int PCI_MIN_RUN = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_src,
    input  logic             pci_src,
    input  logic             agp_src,
    input  logic             ref_src,
    input  logic             usb_src,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             agp_stop_n,
    input  logic             pd_n,
    input  logic             cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic             pci_free_en,
    input  logic [N_AGP-1:0] agp_en,
    input  logic [N_REF-1:0] ref_en,
    input  logic             usb_en,
    output logic             cpu_t,
    output logic             cpu_c,
    output logic [N_PCI-1:0] pci_clk,
    output logic             pci_free,
    output logic [N_AGP-1:0] agp_clk,
    output logic [N_REF-1:0] ref_clk,
    output logic             usb_clk,
    output logic             pd_ack
);

    localparam int N_GROUPS = 6;

    logic                pd_s;
    logic [N_GROUPS-1:0] parked_w;
    logic [N_PCI-1:0]    pci_comp_w;
    logic                pfree_comp_w;
    logic [N_AGP-1:0]    agp_comp_w;
    logic [N_REF-1:0]    ref_comp_w;
    logic                usb_comp_w;
    logic                quiet_w;

    clkstop_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_pd_sync (
        .clk (clk), .rst (rst), .adv_i (1'b1), .d_i (~pd_n), .q_o (pd_s)
    );

    clkstop_gate #(.N_OUT(1), .MIN_RUN(0), .HAS_STOP(1'b1), .HAS_COMP(1'b1)) u_cpu (
        .clk (clk), .rst (rst), .src_i (cpu_src), .stop_n_i (cpu_stop_n), .pd_i (pd_s),
        .en_i (cpu_en), .out_o (cpu_t), .comp_o (cpu_c), .parked_o (parked_w[0])
    );

    clkstop_gate #(.N_OUT(N_PCI), .MIN_RUN(PCI_MIN_RUN), .HAS_STOP(1'b1), .HAS_COMP(1'b0)) u_pci (
        .clk (clk), .rst (rst), .src_i (pci_src), .stop_n_i (pci_stop_n), .pd_i (pd_s),
        .en_i (pci_en), .out_o (pci_clk), .comp_o (pci_comp_w), .parked_o (parked_w[1])
    );

    clkstop_gate #(.N_OUT(1), .MIN_RUN(0), .HAS_STOP(1'b0), .HAS_COMP(1'b0)) u_pci_free (
        .clk (clk), .rst (rst), .src_i (pci_src), .stop_n_i (pci_stop_n), .pd_i (pd_s),
        .en_i (pci_free_en), .out_o (pci_free), .comp_o (pfree_comp_w), .parked_o (parked_w[2])
    );

    clkstop_gate #(.N_OUT(N_AGP), .MIN_RUN(0), .HAS_STOP(1'b1), .HAS_COMP(1'b0)) u_agp (
        .clk (clk), .rst (rst), .src_i (agp_src), .stop_n_i (agp_stop_n), .pd_i (pd_s),
        .en_i (agp_en), .out_o (agp_clk), .comp_o (agp_comp_w), .parked_o (parked_w[3])
    );

    clkstop_gate #(.N_OUT(N_REF), .MIN_RUN(0), .HAS_STOP(1'b0), .HAS_COMP(1'b0)) u_ref (
        .clk (clk), .rst (rst), .src_i (ref_src), .stop_n_i (1'b1), .pd_i (pd_s),
        .en_i (ref_en), .out_o (ref_clk), .comp_o (ref_comp_w), .parked_o (parked_w[4])
    );

    clkstop_gate #(.N_OUT(1), .MIN_RUN(0), .HAS_STOP(1'b0), .HAS_COMP(1'b0)) u_usb (
        .clk (clk), .rst (rst), .src_i (usb_src), .stop_n_i (1'b1), .pd_i (pd_s),
        .en_i (usb_en), .out_o (usb_clk), .comp_o (usb_comp_w), .parked_o (parked_w[5])
    );

    assign quiet_w = ~|{cpu_t, cpu_c, pci_clk, pci_comp_w, pci_free, pfree_comp_w,
                        agp_clk, agp_comp_w, ref_clk, ref_comp_w, usb_clk, usb_comp_w};

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_ack <= 1'b0;
        end else begin
            pd_ack <= pd_s & (&parked_w) & quiet_w;
        end
    end

    AST_PD_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> ({cpu_t, cpu_c, pci_clk, pci_free, agp_clk, ref_clk, usb_clk} == '0)); // R9

    AST_CPU_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cpu_t && cpu_c)); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!pd_ack && !cpu_t && !cpu_c && (pci_clk == '0) && !pci_free)); // R1

endmodule

// File: tb/clkstop_ctrl_bench.sv
module clkstop_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_PCI = 10;
    localparam int N_AGP = 3;
    localparam int N_REF = 3;
    localparam int MIN_RUN = 10;
    localparam int NT = 8;
    localparam int WIN = 120;   // common multiple of all source periods

    logic clk;
    logic rst;
    logic cpu_src, pci_src, agp_src, ref_src, usb_src;
    logic cpu_stop_n, pci_stop_n, agp_stop_n, pd_n;
    logic cpu_en, pci_free_en, usb_en;
    logic [N_PCI-1:0] pci_en;
    logic [N_AGP-1:0] agp_en;
    logic [N_REF-1:0] ref_en;
    logic cpu_t, cpu_c, pci_free, usb_clk, pd_ack;
    logic [N_PCI-1:0] pci_clk;
    logic [N_AGP-1:0] agp_clk;
    logic [N_REF-1:0] ref_clk;

    int tick;
    int n_cmp;
    int n_bad;
    bit done;
    int rises [NT];
    int widths [NT];
    int runts;
    string req_q[$];
    int    exp_q[$];
    int    act_q[$];

    // tracked: 0 cpu_t, 1 cpu_c, 2 pci_clk[0], 3 pci_free, 4 agp_clk[0], 5 ref_clk[0], 6 usb_clk, 7 pci_clk[1]
    logic [NT-1:0] trk;
    assign trk = {pci_clk[1], usb_clk, ref_clk[0], agp_clk[0], pci_free, pci_clk[0], cpu_c, cpu_t};

    assign cpu_src = (tick % 4) < 2;
    assign pci_src = (tick % 8) < 4;
    assign agp_src = (tick % 6) < 3;
    assign ref_src = (tick % 10) < 5;
    assign usb_src = (tick % 4) < 2;

    clkstop_ctrl #(.N_PCI(N_PCI), .N_AGP(N_AGP), .N_REF(N_REF), .PCI_MIN_RUN(MIN_RUN)) u_clkstop_ctrl (
        .clk (clk), .rst (rst),
        .cpu_src (cpu_src), .pci_src (pci_src), .agp_src (agp_src), .ref_src (ref_src), .usb_src (usb_src),
        .cpu_stop_n (cpu_stop_n), .pci_stop_n (pci_stop_n), .agp_stop_n (agp_stop_n), .pd_n (pd_n),
        .cpu_en (cpu_en), .pci_en (pci_en), .pci_free_en (pci_free_en), .agp_en (agp_en),
        .ref_en (ref_en), .usb_en (usb_en),
        .cpu_t (cpu_t), .cpu_c (cpu_c), .pci_clk (pci_clk), .pci_free (pci_free),
        .agp_clk (agp_clk), .ref_clk (ref_clk), .usb_clk (usb_clk), .pd_ack (pd_ack)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        tick = 0;
        forever begin
            @(negedge clk);
            tick = tick + 1;
        end
    end

    // Edge counter and pulse-width monitor (R2, R10)
    initial begin
        logic [NT-1:0] prev;
        int hw [NT];
        hw = '{2, 2, 4, 4, 3, 5, 2, 4};
        prev = '0;
        runts = 0;
        for (int i = 0; i < NT; i++) begin
            rises[i] = 0;
            widths[i] = 0;
        end
        forever begin
            @(negedge clk);
            for (int i = 0; i < NT; i++) begin
                if (trk[i] && !prev[i]) rises[i] = rises[i] + 1;
                if (trk[i]) begin
                    widths[i] = widths[i] + 1;
                end else if (prev[i]) begin
                    if (widths[i] != hw[i]) runts = runts + 1;
                    widths[i] = 0;
                end
            end
            prev = trk;
        end
    end

    // Scoreboard monitor: pops expected and observed items and compares them.
    initial begin
        string r;
        int e;
        int a;
        n_cmp = 0;
        n_bad = 0;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                r = req_q.pop_front();
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_cmp = n_cmp + 1;
                if (e != a) begin
                    n_bad = n_bad + 1;
                    $display("FAIL %s: actual %0d expected %0d", r, a, e);
                end
            end
        end
    end

    task automatic expect_item(input string r, input int e, input int a);
        req_q.push_back(r);
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    task automatic window(input int len, output int d [NT]);
        int s [NT];
        @(posedge clk);
        s = rises;
        repeat (len) @(posedge clk);
        for (int i = 0; i < NT; i++) d[i] = rises[i] - s[i];
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int d [NT];
        int s0;
        int guard;
        done = 1'b0;
        rst = 1'b1;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; agp_stop_n = 1'b1; pd_n = 1'b1;
        cpu_en = 1'b1; pci_free_en = 1'b1; usb_en = 1'b1;
        pci_en = '1; agp_en = '1; ref_en = '1;
        wait_clk(6);
        // R1: quiet during reset
        expect_item("R1 outputs in reset", 0,
            int'(|{cpu_t, cpu_c, pci_clk, pci_free, agp_clk, ref_clk, usb_clk}));
        expect_item("R1 pd_ack in reset", 0, int'(pd_ack));
        rst = 1'b0;
        wait_clk(40);

        // R10: free running counts
        window(WIN, d);
        expect_item("R10 cpu_t rises", 30, d[0]);
        expect_item("R10 cpu_c rises", 30, d[1]);
        expect_item("R10 pci rises", 15, d[2]);
        expect_item("R10 agp rises", 20, d[4]);
        expect_item("R10 ref rises", 12, d[5]);
        expect_item("R10 usb rises", 30, d[6]);

        // R3 / R4: processor stop
        cpu_stop_n = 1'b0;
        wait_clk(16);
        window(WIN, d);
        expect_item("R3 cpu_t stopped", 0, d[0]);
        expect_item("R3 cpu_c stopped", 0, d[1]);
        expect_item("R3 cpu_t parked low", 0, int'(cpu_t));
        expect_item("R4 pci running", 15, d[2]);
        expect_item("R4 agp running", 20, d[4]);
        expect_item("R4 ref running", 12, d[5]);
        expect_item("R4 usb running", 30, d[6]);
        @(negedge clk);
        cpu_stop_n = 1'b1;
        window(16, d);
        expect_item("R3 cpu restart within 4 periods", 1, int'(d[0] >= 1));
        wait_clk(40);

        // R5: peripheral stop, free-running output keeps going
        pci_stop_n = 1'b0;
        wait_clk(32);
        window(WIN, d);
        expect_item("R5 pci gated stopped", 0, d[2]);
        expect_item("R5 pci free keeps running", 15, d[3]);
        expect_item("R5 pci second output stopped", 0, d[7]);

        // R6: minimum run after restart
        @(posedge clk);
        s0 = rises[2];
        @(negedge clk);
        pci_stop_n = 1'b1;
        guard = 0;
        while (!pci_clk[0] && guard < 200) begin
            @(negedge clk);
            guard = guard + 1;
        end
        pci_stop_n = 1'b0;
        wait_clk(240);
        @(posedge clk);
        expect_item("R6 pulses before re-stop >= min run", 1, int'((rises[2] - s0) >= MIN_RUN));
        expect_item("R6 re-stop does take effect", 1, int'((rises[2] - s0) <= MIN_RUN + 2));
        @(negedge clk);
        pci_stop_n = 1'b1;
        wait_clk(40);

        // R7: graphics stop
        agp_stop_n = 1'b0;
        wait_clk(18);
        window(WIN, d);
        expect_item("R7 agp stopped", 0, d[4]);
        expect_item("R7 pci unaffected", 15, d[2]);
        @(negedge clk);
        agp_stop_n = 1'b1;
        wait_clk(40);

        // R8: enable bits
        pci_en[0] = 1'b0;
        ref_en[0] = 1'b0;
        wait_clk(24);
        window(WIN, d);
        expect_item("R8 disabled pci held low", 0, d[2]);
        expect_item("R8 neighbour pci runs", 15, d[7]);
        expect_item("R8 disabled ref held low", 0, d[5]);
        @(negedge clk);
        pci_en[0] = 1'b1;
        ref_en[0] = 1'b1;
        wait_clk(40);

        // R9: power-down overrides everything; stop inputs held released
        pd_n = 1'b0;
        wait_clk(30);
        window(WIN, d);
        expect_item("R9 all outputs parked", 0, d[0] + d[1] + d[2] + d[3] + d[4] + d[5] + d[6] + d[7]);
        @(negedge clk);
        expect_item("R9 pd_ack high", 1, int'(pd_ack));
        expect_item("R9 levels low", 0,
            int'(|{cpu_t, cpu_c, pci_clk, pci_free, agp_clk, ref_clk, usb_clk}));
        pd_n = 1'b1;
        wait_clk(60);
        expect_item("R9 pd_ack released", 0, int'(pd_ack));
        window(WIN, d);
        expect_item("R9 cpu resumes", 30, d[0]);
        expect_item("R9 pci free resumes", 15, d[3]);
        expect_item("R9 ref resumes", 12, d[5]);

        // R2: no shortened pulse seen across all of the above
        @(negedge clk);
        expect_item("R2 runt pulses", 0, runts);

        wait_clk(4);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule